// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the memory-mapped state store of an interrupt distributor for up to 64 interrupt IDs. Software reaches it through a simple 32-bit register bus with per-byte write enables. For every implemented ID it keeps an enable bit, a pending bit, a group bit, an 8-bit priority and an 8-bit CPU target mask. A small control register gates forwarding per group, and a packed write register starts software interrupts on IDs 0 to 15.

Enable and pending state are changed through paired set and clear addresses, so software never needs a read-modify-write. Every ID word and byte that has no implemented interrupt behind it reads as zero, so that software can find the size of the bank by writing all ones and reading back. Toward the CPU interface the block exports the vector of interrupts that may be forwarded, with their priorities and groups. It takes back an acknowledge strobe with an ID, which clears that ID's pending bit.

Top module: `distr_bank`

## Requirements
- R1: Control word at byte address 0x000. Bit 0 enables forwarding of group 0 and bit 1 enables forwarding of group 1. Both bits read back, and all other bits read as zero.
- R2: Each enable word covers 32 IDs. The word for ID n is at 0x100 + 4*(n/32) for set and 0x180 + 4*(n/32) for clear, and bit n%32 belongs to ID n. Writing a 1 sets or clears that enable, a 0 leaves it alone, and both addresses read the current enables.
- R3: Pending bits use the same layout at 0x200 (set) and 0x280 (clear). A set-pending write to IDs 0 to 15 has no effect, while clear-pending works on every ID.
- R4: Group bits are read/write at 0x080 + 4*(n/32), bit n%32, where 0 selects group 0 and 1 selects group 1.
- R5: The priority of ID n is the byte at 0x400 + n, in byte lane n%4 of its word. Only the lanes whose byte enable is set are written.
- R6: The target mask of ID n is the byte at 0x800 + n, in bits [8*(n%4)+7 : 8*(n%4)] of its word.
- R7: A write to 0x180 + 0xD80 = 0xF00 with all four byte enables set holds the ID in bits [3:0], a group selector in bit 15 and a CPU list in bits [23:16]. It sets that ID's pending bit only when list bit CPU_SELF (default 0) is 1 and bit 15 equals the ID's group bit. A write with any other byte-enable pattern is ignored, and the address reads as zero.
- R8: IDs at or above IRQ_COUNT read as zero in every per-ID register, and writes to them have no effect. Addresses outside the map read as zero.
- R9: fwdPend[n] is 1 exactly when ID n is enabled and pending and its group is enabled in the control word. irqPrio and irqGroup mirror the stored priority and group of each ID.
- R10: An acknowledge strobe clears the pending bit of ackId at the next edge. If a set reaches the same ID in the same cycle, the set wins.
- R11: busWrAck is high for one cycle in the cycle after each write. Read data is combinational in the same cycle as busSel, and it is zero when no read is selected.
- R12: In the bit registers (enable, pending, group) a byte lane whose enable is low leaves its eight IDs unchanged.
- R13: After reset all enables, pendings, groups, priorities, targets and control bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte-lane write enables |
| busRdata | output | 32 | Read data, same cycle |
| busWrAck | output | 1 | Write completion, one cycle after the write |
| ackValid | input | 1 | Acknowledge strobe from the CPU interface |
| ackId | input | $clog2(IRQ_COUNT) | ID being acknowledged |
| fwdPend | output | IRQ_COUNT | Enabled, pending and group-enabled vector |
| irqPrio | output | 8*IRQ_COUNT | Priority byte per ID, ID n at [8n+7:8n] |
| irqGroup | output | IRQ_COUNT | Group bit per ID |

## Verification
The bench goes after the places where the paired registers and the packed software write can go wrong. It checks that a set-pending write of all ones leaves IDs 0 to 15 untouched; a design that ignored this rule would show those low bits as set. It checks that words past the last implemented ID read zero after an all-ones write; a design that decoded them would break size discovery. It also checks that a lane-gated write touches only its byte, that a software write with the wrong group bit, a list without this CPU, or a partial byte enable pends nothing, and that a set arriving with an acknowledge on the same ID leaves the pending bit set. A design that let the clear win there would lose that interrupt.

// File: rtl/distr_pkg.sv
package distr_pkg;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_GROUP, RD_ENABLE, RD_PEND, RD_PRIO, RD_TARGET
  } rdSel_t;

  typedef struct packed {
    logic       ctrlWr;
    logic       grpWr;
    logic       setEn;
    logic       clrEn;
    logic       setPend;
    logic       clrPend;
    logic       prioWr;
    logic       tgtWr;
    logic       sgiWr;
    rdSel_t     rdSel;
    logic [7:0] word;
    logic [3:0] be;
  } strobes_t;

endpackage

// File: rtl/distr_ctrl.sv
module distr_ctrl
  import distr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [3:0]  busBe,
  output strobes_t    strb,
  output logic        busWrAck
);

  logic wrNow, rdNow;
  logic isCtrl, isGrp, isSetEn, isClrEn, isSetP, isClrP, isPrio, isTgt, isSgi;
  logic unusedAddrLow;

  assign unusedAddrLow = ^busAddr[1:0];
  assign wrNow = busSel & busWrite;
  assign rdNow = busSel & ~busWrite;

  assign isCtrl  = (busAddr[11:2] == 10'd0);
  assign isGrp   = (busAddr[11:7] == 5'd1);
  assign isSetEn = (busAddr[11:7] == 5'd2);
  assign isClrEn = (busAddr[11:7] == 5'd3);
  assign isSetP  = (busAddr[11:7] == 5'd4);
  assign isClrP  = (busAddr[11:7] == 5'd5);
  assign isPrio  = (busAddr[11:10] == 2'b01);
  assign isTgt   = (busAddr[11:10] == 2'b10);
  assign isSgi   = (busAddr[11:2] == 10'h3C0);

  always_comb begin
    strb         = '0;
    strb.be      = busBe;
    strb.word    = (isPrio || isTgt) ? busAddr[9:2] : {3'b000, busAddr[6:2]};
    strb.ctrlWr  = wrNow & isCtrl;
    strb.grpWr   = wrNow & isGrp;
    strb.setEn   = wrNow & isSetEn;
    strb.clrEn   = wrNow & isClrEn;
    strb.setPend = wrNow & isSetP;
    strb.clrPend = wrNow & isClrP;
    strb.prioWr  = wrNow & isPrio;
    strb.tgtWr   = wrNow & isTgt;
    strb.sgiWr   = wrNow & isSgi;
    strb.rdSel   = RD_NONE;
    if (rdNow) begin
      if (isCtrl)                 strb.rdSel = RD_CTRL;
      else if (isGrp)             strb.rdSel = RD_GROUP;
      else if (isSetEn | isClrEn) strb.rdSel = RD_ENABLE;
      else if (isSetP | isClrP)   strb.rdSel = RD_PEND;
      else if (isPrio)            strb.rdSel = RD_PRIO;
      else if (isTgt)             strb.rdSel = RD_TARGET;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busWrAck <= 1'b0;
    else       busWrAck <= wrNow;
  end

endmodule

// File: rtl/distr_regs.sv
module distr_regs
  import distr_pkg::*;
#(
  parameter int IRQ_COUNT = 64,
  parameter int CPU_SELF  = 0,
  localparam int ID_W       = $clog2(IRQ_COUNT),
  localparam int BIT_WORDS  = (IRQ_COUNT + 31) / 32,
  localparam int BYTE_WORDS = (IRQ_COUNT + 3) / 4,
  localparam int SGI_COUNT  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strb,
  input  logic [31:0]            wdata,
  input  logic                   ackValid,
  input  logic [ID_W-1:0]        ackId,
  output logic [31:0]            rdata,
  output logic [IRQ_COUNT-1:0]   fwdPend,
  output logic [8*IRQ_COUNT-1:0] irqPrio,
  output logic [IRQ_COUNT-1:0]   irqGroup,
  output logic [1:0]             grpEn
);

  logic [IRQ_COUNT-1:0]    enV, pendV, grpV;
  logic [BIT_WORDS*32-1:0] enPad, pendPad, grpPad;
  logic [BYTE_WORDS*32-1:0] prioPad, tgtPad;
  logic [31:0] laneMask, effData;
  logic [15:0] sgiGrp;
  logic        sgiFire;
  logic [1:0]  ctrlR;

  assign laneMask = {{8{strb.be[3]}}, {8{strb.be[2]}}, {8{strb.be[1]}}, {8{strb.be[0]}}};
  assign effData  = wdata & laneMask;
  assign sgiGrp   = grpV[15:0];
  assign sgiFire  = strb.sgiWr && (strb.be == 4'hF) && wdata[16 + CPU_SELF]
                    && (wdata[15] == sgiGrp[wdata[3:0]]);

  always_ff @(posedge clk) begin
    if (!rstN)                         ctrlR <= 2'b00;
    else if (strb.ctrlWr && strb.be[0]) ctrlR <= wdata[1:0];
  end
  assign grpEn = ctrlR;

  for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_id
    localparam int W = i / 32;
    localparam int B = i % 32;
    localparam int L = i % 4;
    localparam bit CAN_SET = (i >= SGI_COUNT);
    localparam bit IS_SGI  = (i < SGI_COUNT);
    logic en, pend, grp;
    logic [7:0] pr, tg;
    logic bitHit, byteHit, setNow, clrNow;

    assign bitHit  = (strb.word == 8'(W)) && effData[B];
    assign byteHit = (strb.word == 8'(i / 4)) && strb.be[L];
    assign setNow  = (CAN_SET && strb.setPend && bitHit)
                   || (IS_SGI && sgiFire && (wdata[3:0] == 4'(i)));
    assign clrNow  = (strb.clrPend && bitHit) || (ackValid && (ackId == ID_W'(i)));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en <= 1'b0; pend <= 1'b0; grp <= 1'b0; pr <= 8'h00; tg <= 8'h00;
      end else begin
        if (strb.setEn && bitHit)      en <= 1'b1;
        else if (strb.clrEn && bitHit) en <= 1'b0;
        if (setNow)      pend <= 1'b1;
        else if (clrNow) pend <= 1'b0;
        if (strb.grpWr && (strb.word == 8'(W)) && strb.be[B / 8]) grp <= wdata[B];
        if (strb.prioWr && byteHit) pr <= wdata[8*L +: 8];
        if (strb.tgtWr && byteHit)  tg <= wdata[8*L +: 8];
      end
    end

    assign enV[i]          = en;
    assign pendV[i]        = pend;
    assign grpV[i]         = grp;
    assign prioPad[8*i +: 8] = pr;
    assign tgtPad[8*i +: 8]  = tg;
  end

  if (BYTE_WORDS * 4 > IRQ_COUNT) begin : g_byte_tail
    assign prioPad[BYTE_WORDS*32-1 : 8*IRQ_COUNT] = '0;
    assign tgtPad[BYTE_WORDS*32-1 : 8*IRQ_COUNT]  = '0;
  end

  assign enPad   = (BIT_WORDS*32)'(enV);
  assign pendPad = (BIT_WORDS*32)'(pendV);
  assign grpPad  = (BIT_WORDS*32)'(grpV);

  always_comb begin
    int idx;
    idx   = int'(strb.word);
    rdata = '0;
    unique case (strb.rdSel)
      RD_CTRL:   rdata = {30'd0, ctrlR};
      RD_GROUP:  if (idx < BIT_WORDS)  rdata = grpPad[32*idx +: 32];
      RD_ENABLE: if (idx < BIT_WORDS)  rdata = enPad[32*idx +: 32];
      RD_PEND:   if (idx < BIT_WORDS)  rdata = pendPad[32*idx +: 32];
      RD_PRIO:   if (idx < BYTE_WORDS) rdata = prioPad[32*idx +: 32];
      RD_TARGET: if (idx < BYTE_WORDS) rdata = tgtPad[32*idx +: 32];
      default:   rdata = '0;
    endcase
  end

  assign fwdPend  = enV & pendV & ((grpV & {IRQ_COUNT{ctrlR[1]}}) | (~grpV & {IRQ_COUNT{ctrlR[0]}}));
  assign irqPrio  = prioPad[8*IRQ_COUNT-1:0];
  assign irqGroup = grpV;

endmodule

// File: rtl/distr_bank.sv
module distr_bank
  import distr_pkg::*;
#(
  parameter int IRQ_COUNT = 64,
  parameter int CPU_SELF  = 0,
  localparam int ID_W = $clog2(IRQ_COUNT)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [11:0]            busAddr,
  input  logic [31:0]            busWdata,
  input  logic [3:0]             busBe,
  output logic [31:0]            busRdata,
  output logic                   busWrAck,
  input  logic                   ackValid,
  input  logic [ID_W-1:0]        ackId,
  output logic [IRQ_COUNT-1:0]   fwdPend,
  output logic [8*IRQ_COUNT-1:0] irqPrio,
  output logic [IRQ_COUNT-1:0]   irqGroup
);

  strobes_t   strb;
  logic [1:0] grpEn;

  distr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .strb(strb), .busWrAck(busWrAck)
  );

  distr_regs #(.IRQ_COUNT(IRQ_COUNT), .CPU_SELF(CPU_SELF)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .ackValid(ackValid), .ackId(ackId), .rdata(busRdata),
    .fwdPend(fwdPend), .irqPrio(irqPrio), .irqGroup(irqGroup), .grpEn(grpEn)
  );

endmodule

// File: rtl/distr_bank_chk.sv
module distr_bank_chk #(
  parameter int IRQ_COUNT = 64,
  localparam int ID_W = $clog2(IRQ_COUNT)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [11:0]          busAddr,
  input logic [31:0]          busRdata,
  input logic                 busWrAck,
  input logic                 ackValid,
  input logic [ID_W-1:0]      ackId,
  input logic [IRQ_COUNT-1:0] fwdPend,
  input logic [IRQ_COUNT-1:0] irqGroup,
  input logic [1:0]           grpEn
);

  p_wrack_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite) |=> busWrAck);

  p_no_wrack_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |=> !busWrAck);

  p_grp0_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|(fwdPend & ~irqGroup)) |-> grpEn[0]);

  p_grp1_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|(fwdPend & irqGroup)) |-> grpEn[1]);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !(busSel && busWrite)) |=> !fwdPend[$past(ackId)]);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr[11:10] == 2'b11) |-> (busRdata == 32'd0));

endmodule

bind distr_bank distr_bank_chk #(.IRQ_COUNT(IRQ_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .busWrAck(busWrAck),
  .ackValid(ackValid), .ackId(ackId), .fwdPend(fwdPend),
  .irqGroup(irqGroup), .grpEn(grpEn)
);

// File: tb/distr_bank_test.sv
`timescale 1ns/1ps
module distr_bank_test;

  localparam int IRQ_COUNT = 64;
  localparam int ID_W = $clog2(IRQ_COUNT);
  localparam int NVEC = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdata;
  logic        busWrAck;
  logic        ackValid = 1'b0;
  logic [ID_W-1:0] ackId = '0;
  logic [IRQ_COUNT-1:0]   fwdPend, irqGroup;
  logic [8*IRQ_COUNT-1:0] irqPrio;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  distr_bank uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busBe(busBe),
    .busRdata(busRdata), .busWrAck(busWrAck), .ackValid(ackValid),
    .ackId(ackId), .fwdPend(fwdPend), .irqPrio(irqPrio), .irqGroup(irqGroup)
  );

  // {write, addr, data, be, expected read}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 12'h100, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R2 set all
    {1'b0, 12'h100, 32'h0, 4'h0, 32'hFFFF_FFFF},          // R2
    {1'b0, 12'h180, 32'h0, 4'h0, 32'hFFFF_FFFF},          // R2 clear addr reads state
    {1'b1, 12'h180, 32'h0000_FFFF, 4'hF, 32'h0},          // R2 clear low half
    {1'b0, 12'h100, 32'h0, 4'h0, 32'hFFFF_0000},          // R2
    {1'b1, 12'h104, 32'hFFFF_FFFF, 4'h1, 32'h0},          // R12 lane 0 only
    {1'b0, 12'h104, 32'h0, 4'h0, 32'h0000_00FF},          // R12
    {1'b1, 12'h108, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R8 beyond IDs
    {1'b0, 12'h108, 32'h0, 4'h0, 32'h0},                  // R8
    {1'b1, 12'h200, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R3 set pend
    {1'b0, 12'h200, 32'h0, 4'h0, 32'hFFFF_0000},          // R3 IDs 0..15 untouched
    {1'b1, 12'h280, 32'h00FF_0000, 4'hF, 32'h0},          // R3 clear
    {1'b0, 12'h280, 32'h0, 4'h0, 32'hFF00_0000},          // R3
    {1'b1, 12'h080, 32'h0000_F0F0, 4'hF, 32'h0},          // R4
    {1'b0, 12'h080, 32'h0, 4'h0, 32'h0000_F0F0},          // R4
    {1'b1, 12'h404, 32'hAABB_CCDD, 4'h5, 32'h0},          // R5 IDs 4 and 6
    {1'b0, 12'h404, 32'h0, 4'h0, 32'h00BB_00DD},          // R5
    {1'b1, 12'h83C, 32'h1122_3344, 4'h8, 32'h0},          // R6 ID 63
    {1'b0, 12'h83C, 32'h0, 4'h0, 32'h1100_0000},          // R6
    {1'b1, 12'h440, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R8 prio beyond IDs
    {1'b0, 12'h440, 32'h0, 4'h0, 32'h0},                  // R8
    {1'b1, 12'h000, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R1
    {1'b0, 12'h000, 32'h0, 4'h0, 32'h0000_0003},          // R1
    {1'b0, 12'hF00, 32'h0, 4'h0, 32'h0},                  // R7 reads zero
    {1'b0, 12'hC00, 32'h0, 4'h0, 32'h0},                  // R8 unmapped
    {1'b1, 12'h208, 32'hFFFF_FFFF, 4'hF, 32'h0},          // R8 pend beyond IDs
    {1'b0, 12'h208, 32'h0, 4'h0, 32'h0}                   // R8
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busBe = be;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busBe = '0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic ackPulse(input int id);
    @(negedge clk);
    ackValid = 1'b1; ackId = ID_W'(id);
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R13 reset state
    busRd(12'h100, rd); check("R13 enable", 64'(rd), 64'h0);
    busRd(12'h000, rd); check("R13 control", 64'(rd), 64'h0);
    busRd(12'h404, rd); check("R13 priority", 64'(rd), 64'h0);
    check("R13 fwdPend", 64'(fwdPend), 64'h0);
    check("R13 busWrAck", 64'(busWrAck), 64'h0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][80]) busWr(VEC[k][79:68], VEC[k][67:36], VEC[k][35:32]);
      else begin
        busRd(VEC[k][79:68], rd);
        check($sformatf("table[%0d]", k), 64'(rd), 64'(VEC[k][31:0]));
      end
    end

    // R9 forwarding: IDs 24..31 enabled, pending, group 0
    check("R9 fwd both groups on", 64'(fwdPend), 64'h0000_0000_FF00_0000);
    check("R9 irqPrio ID4", 64'(irqPrio[4*8 +: 8]), 64'hDD);
    check("R9 irqGroup", 64'(irqGroup), 64'h0000_0000_0000_F0F0);
    busWr(12'h000, 32'h2, 4'hF);
    check("R9 group 0 disabled", 64'(fwdPend), 64'h0);
    busWr(12'h080, 32'h0F00_F0F0, 4'hF);
    check("R9 IDs 24..27 in group 1", 64'(fwdPend), 64'h0000_0000_0F00_0000);
    busWr(12'h000, 32'h3, 4'hF);

    // R11 write response and idle read data
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 12'h100; busWdata = 32'h0000_FFFF; busBe = 4'hF;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    check("R11 ack after write", 64'(busWrAck), 64'h1);
    @(negedge clk);
    check("R11 ack one cycle", 64'(busWrAck), 64'h0);
    check("R11 idle rdata", 64'(busRdata), 64'h0);

    // R7 software interrupts: ID 5 is group 1, ID 3 is group 0
    busWr(12'hF00, 32'h0001_8005, 4'hF);
    busRd(12'h200, rd); check("R7 sgi id5 pends", 64'(rd), 64'hFF00_0020);
    busWr(12'hF00, 32'h0001_8003, 4'hF);
    busRd(12'h200, rd); check("R7 wrong group ignored", 64'(rd), 64'hFF00_0020);
    busWr(12'hF00, 32'h0002_0003, 4'hF);
    busRd(12'h200, rd); check("R7 other cpu ignored", 64'(rd), 64'hFF00_0020);
    busWr(12'hF00, 32'h0001_0002, 4'h7);
    busRd(12'h200, rd); check("R7 partial be ignored", 64'(rd), 64'hFF00_0020);
    busWr(12'hF00, 32'h0003_0003, 4'hF);
    busRd(12'h200, rd); check("R7 id3 pends", 64'(rd), 64'hFF00_0028);

    // R10 acknowledge
    ackPulse(5);
    busRd(12'h200, rd); check("R10 ack clears id5", 64'(rd), 64'hFF00_0008);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 12'hF00; busWdata = 32'h0001_0003; busBe = 4'hF;
    ackValid = 1'b1; ackId = ID_W'(3);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; ackValid = 1'b0;
    busRd(12'h200, rd); check("R10 set wins over ack", 64'(rd), 64'hFF00_0008);
    ackPulse(24);
    busRd(12'h200, rd); check("R10 ack id24", 64'(rd), 64'hFE00_0008);

    // R13 reset again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRd(12'h200, rd); check("R13 pend after reset", 64'(rd), 64'h0);
    busRd(12'h83C, rd); check("R13 target after reset", 64'(rd), 64'h0);
    check("R13 fwdPend after reset", 64'(fwdPend), 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule